// File: doc/BRIEF.md
# Accumulator Microoperation Sequencer

This block executes the manipulation group of a 12-bit operate instruction against a word-wide accumulator and a one-bit link flag. A one-cycle start pulse hands it the instruction word together with the current accumulator and link. Every operation bit set in that word is then applied in four ordered steps, one step per clock:

- clearing,
- complementing,
- incrementing,
- one final reshaping of the link-plus-accumulator loop (single rotate, double rotate or half-word exchange).

When the last step is done, the updated accumulator and link appear with a one-cycle done pulse, and they stay on the outputs until the next accepted start.

The word layout numbers bit 0 as the most significant instruction bit, which is `instr_i[11]`. Bit n therefore sits at `instr_i[11-n]`. Accumulator bit 0 is likewise its most significant bit. In the rotate loop the link sits directly above the accumulator's most significant bit.

Top module: `acc_uop_seq`

## Requirements
- R1: A word is accepted as manipulation-group only when `instr_i[11:9]` is 3'b111 and `instr_i[8]` is 0. Any other word leaves AC and L unchanged and reports `illegal_o`=1 with done.
- R2: Step 1: `instr_i[7]` clears AC to zero and `instr_i[6]` clears L.
- R3: Step 2 runs after step 1: `instr_i[5]` replaces AC with its one's complement and `instr_i[4]` inverts L. With both clear and complement set, L ends at 1 and AC ends at all ones.
- R4: Step 3: `instr_i[0]` adds one to AC. Combined with `instr_i[5]` this yields the two's complement. An increment carrying out of all-ones inverts L.
- R5: Step 4: `instr_i[3]` rotates the loop {L,AC} right by one place, and `instr_i[2]` rotates it left by one place.
- R6: When `instr_i[1]` is also set, the rotation of R5 moves two places instead of one.
- R7: `instr_i[1]` with `instr_i[3:2]`=0 exchanges the upper half of AC with the lower half, leaving L unchanged.
- R8: `instr_i[3]` and `instr_i[2]` both set makes step 4 leave AC and L unchanged and reports `illegal_o`=1. Steps 1 to 3 still apply.
- R9: Clear AC followed by a single left rotate leaves the old link in AC bit 11 (`ac_o[0]`), and leaves L = 0.
- R10: A group word with `instr_i[7:0]`=0 returns AC and L unchanged, with `illegal_o`=0.
- R11: A start seen while idle is accepted at that edge. `busy_o` is high from the next cycle until the cycle after done. `done_o` is high for exactly one cycle, beginning at the fourth rising edge after the accepting edge.
- R12: A start presented while `busy_o` is high, including the done cycle, is ignored.
- R13: `ac_o`, `link_o` and `illegal_o` hold their values while idle. After reset they are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| instr_i | input | 12 | Instruction word |
| ac_i | input | AC_W | Accumulator value to operate on |
| link_i | input | 1 | Link value to operate on |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ac_o | output | AC_W | Resulting accumulator |
| link_o | output | 1 | Resulting link |
| illegal_o | output | 1 | Instruction outside the group, or both rotate directions requested |

## Verification
The bench builds the block with its defaults: `AC_W`=12 and `CARRY_FLIPS_LINK`=1. This width makes the half swap a pair of 6-bit fields and the rotate loop 13 bits, so the double rotates visibly carry bits through the link. With the carry option enabled, the all-ones increment exercises the link inversion. The directed vectors reach the wrap-around edges of both rotate directions, the step ordering (clear before complement, complement before increment, clear before rotate), the conflicting rotate request and starts that arrive mid-operation.

// File: rtl/acc_uop_pkg.sv
package acc_uop_pkg;
   localparam int INSTR_W = 12;

   // instruction bit positions (LSB-based index into instr_i)
   localparam int B_CLR_AC = 7;
   localparam int B_CLR_LK = 6;
   localparam int B_CPL_AC = 5;
   localparam int B_CPL_LK = 4;
   localparam int B_ROT_R  = 3;
   localparam int B_ROT_L  = 2;
   localparam int B_MOD    = 1;
   localparam int B_INC    = 0;

   typedef struct packed {
      logic clr_ac;
      logic clr_lk;
      logic cpl_ac;
      logic cpl_lk;
      logic inc;
      logic rot_r;
      logic rot_l;
      logic twice;
      logic swap;
      logic hold4;
      logic illegal;
   } uop_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_S1, ST_S2, ST_S3, ST_S4, ST_DONE
   } seq_state_t;
endpackage

// File: rtl/acc_uop_decode.sv
module acc_uop_decode
   import acc_uop_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output uop_t               uop
);
   logic in_grp;
   logic both_rot;

   always_comb begin
      in_grp   = (instr[11:9] == 3'b111) && !instr[8];
      both_rot = instr[B_ROT_R] && instr[B_ROT_L];
      uop.clr_ac  = in_grp && instr[B_CLR_AC];
      uop.clr_lk  = in_grp && instr[B_CLR_LK];
      uop.cpl_ac  = in_grp && instr[B_CPL_AC];
      uop.cpl_lk  = in_grp && instr[B_CPL_LK];
      uop.inc     = in_grp && instr[B_INC];
      uop.rot_r   = in_grp && instr[B_ROT_R] && !both_rot;
      uop.rot_l   = in_grp && instr[B_ROT_L] && !both_rot;
      uop.twice   = in_grp && instr[B_MOD];
      uop.swap    = in_grp && instr[B_MOD] && !instr[B_ROT_R] && !instr[B_ROT_L];
      uop.hold4   = in_grp && both_rot;
      uop.illegal = !in_grp || both_rot;
   end
endmodule

// File: rtl/acc_uop_step.sv
module acc_uop_step
   import acc_uop_pkg::*;
#(
   parameter int AC_W             = 12,
   parameter int STEP             = 1,
   parameter bit CARRY_FLIPS_LINK = 1'b1
) (
   input  logic [AC_W-1:0] ac,
   input  logic            lk,
   input  uop_t            uop,
   output logic [AC_W-1:0] ac_n,
   output logic            lk_n
);
   localparam int HALF = AC_W / 2;
   localparam int LW   = AC_W + 1;

   generate
      if (STEP == 1) begin : g_clear
         always_comb begin
            ac_n = uop.clr_ac ? '0 : ac;
            lk_n = uop.clr_lk ? 1'b0 : lk;
         end
      end else if (STEP == 2) begin : g_compl
         always_comb begin
            ac_n = uop.cpl_ac ? ~ac : ac;
            lk_n = uop.cpl_lk ? ~lk : lk;
         end
      end else if (STEP == 3) begin : g_incr
         logic [AC_W:0] sum;
         always_comb sum = {1'b0, ac} + {{AC_W{1'b0}}, uop.inc};
         assign ac_n = sum[AC_W-1:0];
         if (CARRY_FLIPS_LINK) begin : g_cy
            assign lk_n = lk ^ sum[AC_W];
         end else begin : g_nocy
            assign lk_n = lk;
         end
      end else begin : g_shape
         logic [LW-1:0] loop_v;
         logic [LW-1:0] loop_n;
         always_comb begin
            loop_v = {lk, ac};
            loop_n = loop_v;
            if (uop.rot_r)
               loop_n = uop.twice ? {loop_v[1:0], loop_v[LW-1:2]}
                                  : {loop_v[0], loop_v[LW-1:1]};
            else if (uop.rot_l)
               loop_n = uop.twice ? {loop_v[LW-3:0], loop_v[LW-1:LW-2]}
                                  : {loop_v[LW-2:0], loop_v[LW-1]};
            else if (uop.swap)
               loop_n = {lk, ac[HALF-1:0], ac[AC_W-1:HALF]};
            ac_n = loop_n[AC_W-1:0];
            lk_n = loop_n[LW-1];
         end
      end
   endgenerate
endmodule

// File: rtl/acc_uop_ctrl.sv
module acc_uop_ctrl
   import acc_uop_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   output logic       accept,
   output logic       step_en,
   output logic [1:0] step_idx,
   output logic       last_step,
   output logic       busy,
   output logic       done
);
   seq_state_t state_q, state_n;

   always_comb begin
      accept    = (state_q == ST_IDLE) && start;
      step_en   = 1'b1;
      step_idx  = 2'd0;
      state_n   = state_q;
      unique case (state_q)
         ST_IDLE: begin step_en = 1'b0; if (start) state_n = ST_S1; end
         ST_S1:   begin step_idx = 2'd0; state_n = ST_S2; end
         ST_S2:   begin step_idx = 2'd1; state_n = ST_S3; end
         ST_S3:   begin step_idx = 2'd2; state_n = ST_S4; end
         ST_S4:   begin step_idx = 2'd3; state_n = ST_DONE; end
         default: begin step_en = 1'b0; state_n = ST_IDLE; end
      endcase
      last_step = (state_q == ST_S4);
      busy      = (state_q != ST_IDLE);
      done      = (state_q == ST_DONE);
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_n;
endmodule

// File: rtl/acc_uop_seq.sv
module acc_uop_seq
   import acc_uop_pkg::*;
#(
   parameter int AC_W             = 12,
   parameter bit CARRY_FLIPS_LINK = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [INSTR_W-1:0]  instr_i,
   input  logic [AC_W-1:0]     ac_i,
   input  logic                link_i,
   output logic                busy_o,
   output logic                done_o,
   output logic [AC_W-1:0]     ac_o,
   output logic                link_o,
   output logic                illegal_o
);
   localparam int NSTEP = 4;

   generate
      if (AC_W < 2 || (AC_W % 2) != 0) begin : g_bad_width
         $error("acc_uop_seq: AC_W must be even and at least 2");
      end
   endgenerate

   logic [INSTR_W-1:0] instr_q;
   logic [AC_W-1:0]    ac_q;
   logic               lk_q;
   logic               ill_q;
   uop_t               uop;
   logic               accept, step_en, last_step;
   logic [1:0]         step_idx;
   logic [AC_W-1:0]    st_ac [NSTEP];
   logic               st_lk [NSTEP];

   acc_uop_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start_i), .accept(accept),
      .step_en(step_en), .step_idx(step_idx), .last_step(last_step),
      .busy(busy_o), .done(done_o)
   );

   acc_uop_decode u_dec (.instr(instr_q), .uop(uop));

   generate
      for (genvar k = 0; k < NSTEP; k++) begin : g_step
         acc_uop_step #(
            .AC_W(AC_W), .STEP(k + 1), .CARRY_FLIPS_LINK(CARRY_FLIPS_LINK)
         ) u_step (
            .ac(ac_q), .lk(lk_q), .uop(uop), .ac_n(st_ac[k]), .lk_n(st_lk[k])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         instr_q <= '0;
         ac_q    <= '0;
         lk_q    <= 1'b0;
         ill_q   <= 1'b0;
      end else if (accept) begin
         instr_q <= instr_i;
         ac_q    <= ac_i;
         lk_q    <= link_i;
      end else if (step_en) begin
         ac_q <= st_ac[step_idx];
         lk_q <= st_lk[step_idx];
         if (last_step) ill_q <= uop.illegal;
      end
   end

   assign ac_o      = ac_q;
   assign link_o    = lk_q;
   assign illegal_o = ill_q;
endmodule

// File: rtl/acc_uop_seq_chk.sv
module acc_uop_seq_chk #(
   parameter int AC_W = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start_i,
   input logic [11:0]     instr_i,
   input logic [AC_W-1:0] ac_i,
   input logic            link_i,
   input logic            busy_o,
   input logic            done_o,
   input logic [AC_W-1:0] ac_o,
   input logic            link_o,
   input logic            illegal_o
);
   logic [11:0]     cap_ins;
   logic [AC_W-1:0] cap_ac;
   logic            cap_lk;
   logic            cap_grp;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         cap_ins <= '0; cap_ac <= '0; cap_lk <= 1'b0;
      end else if (start_i && !busy_o) begin
         cap_ins <= instr_i; cap_ac <= ac_i; cap_lk <= link_i;
      end

   assign cap_grp = (cap_ins[11:9] == 3'b111) && !cap_ins[8];

   assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o |=> busy_o);
   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_outside_group_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !cap_grp |-> illegal_o && ac_o == cap_ac && link_o == cap_lk);
   assert_clear_ac_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && cap_grp && cap_ins[7] && !cap_ins[5] && !cap_ins[0]
      && cap_ins[3:1] == 3'b000 |-> ac_o == '0);
   assert_rot_conflict_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && cap_grp && cap_ins[3] && cap_ins[2] |-> illegal_o);
   assert_nop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && cap_grp && cap_ins[7:0] == 8'h00
      |-> ac_o == cap_ac && link_o == cap_lk && !illegal_o);
   assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && !$past(busy_o) |-> $stable(ac_o) && $stable(link_o));
endmodule

bind acc_uop_seq acc_uop_seq_chk #(.AC_W(AC_W)) u_chk (.*);

// File: tb/acc_uop_seq_bench.sv
`timescale 1ns/1ps
module acc_uop_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [11:0] instr_i = '0;
   logic [11:0] ac_i = '0;
   logic        link_i = 1'b0;
   logic        busy_o, done_o, link_o, illegal_o;
   logic [11:0] ac_o;
   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   acc_uop_seq u_acc_uop_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
      .ac_i(ac_i), .link_i(link_i), .busy_o(busy_o), .done_o(done_o),
      .ac_o(ac_o), .link_o(link_o), .illegal_o(illegal_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0o expected=%0o", req, act, exp);
      end
   endtask

   // one full operation with timing and result checks
   task automatic run_op(input string req, input logic [11:0] ins, input logic [11:0] a,
                         input logic l, input logic [11:0] ea, input logic el,
                         input logic eill);
      @(negedge clk);
      start_i = 1'b1; instr_i = ins; ac_i = a; link_i = l;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      check({req, " R11 busy after accept"}, 32'(busy_o), 32'd1);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check({req, " R11 no early done"}, 32'(done_o), 32'd0);
      @(posedge clk);
      @(negedge clk);
      check({req, " R11 done"}, 32'(done_o), 32'd1);
      check({req, " ac"}, 32'(ac_o), 32'(ea));
      check({req, " link"}, 32'(link_o), 32'(el));
      check({req, " illegal"}, 32'(illegal_o), 32'(eill));
      @(posedge clk);
      @(negedge clk);
      check({req, " R11 done single"}, 32'(done_o), 32'd0);
      check({req, " R11 idle"}, 32'(busy_o), 32'd0);
   endtask

   task automatic t_reset();
      check("R13 reset done", 32'(done_o), 32'd0);
      check("R13 reset busy", 32'(busy_o), 32'd0);
      check("R13 reset ac", 32'(ac_o), 32'd0);
      check("R13 reset link", 32'(link_o), 32'd0);
      check("R13 reset illegal", 32'(illegal_o), 32'd0);
   endtask

   task automatic t_busy_ignore();
      @(negedge clk);
      start_i = 1'b1; instr_i = 12'o7200; ac_i = 12'o1111; link_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      instr_i = 12'o7040; ac_i = 12'o0123; link_i = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R12 done while start held", 32'(done_o), 32'd1);
      check("R12 ac from first op", 32'(ac_o), 32'o0000);
      check("R12 link from first op", 32'(link_o), 32'd1);
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      check("R12 not restarted", 32'(busy_o), 32'd0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R13 ac held", 32'(ac_o), 32'o0000);
      check("R13 link held", 32'(link_o), 32'd1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      run_op("R10 nop",          12'o7000, 12'o1234, 1'b1, 12'o1234, 1'b1, 1'b0);
      run_op("R2 clear both",    12'o7300, 12'o5555, 1'b1, 12'o0000, 1'b0, 1'b0);
      run_op("R3 set link",      12'o7120, 12'o1234, 1'b0, 12'o1234, 1'b1, 1'b0);
      run_op("R3 all ones",      12'o7240, 12'o0123, 1'b0, 12'o7777, 1'b0, 1'b0);
      run_op("R4 negate",        12'o7041, 12'o0005, 1'b0, 12'o7773, 1'b0, 1'b0);
      run_op("R4 carry to link", 12'o7001, 12'o7777, 1'b0, 12'o0000, 1'b1, 1'b0);
      run_op("R5 right",         12'o7010, 12'o0001, 1'b0, 12'o0000, 1'b1, 1'b0);
      run_op("R5 left",          12'o7004, 12'o0001, 1'b1, 12'o0003, 1'b0, 1'b0);
      run_op("R6 left twice",    12'o7006, 12'o4000, 1'b1, 12'o0003, 1'b0, 1'b0);
      run_op("R6 right twice",   12'o7012, 12'o0001, 1'b0, 12'o4000, 1'b0, 1'b0);
      run_op("R7 swap",          12'o7002, 12'o0077, 1'b1, 12'o7700, 1'b1, 1'b0);
      run_op("R8 both rotates",  12'o7014, 12'o1234, 1'b1, 12'o1234, 1'b1, 1'b1);
      run_op("R8 steps 1-3 run", 12'o7215, 12'o1234, 1'b0, 12'o0001, 1'b0, 1'b1);
      run_op("R9 get link",      12'o7204, 12'o5252, 1'b1, 12'o0001, 1'b0, 1'b0);
      run_op("R1 other group",   12'o7400, 12'o1234, 1'b0, 12'o1234, 1'b0, 1'b1);
      run_op("R1 other opcode",  12'o1300, 12'o0707, 1'b1, 12'o0707, 1'b1, 1'b1);
      t_busy_ignore();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule